// File: doc/BRIEF.md
# Calendar Real-Time Clock with Deferred Register Commits

This block is a calendar counter for a real-time clock. It runs on the fast bus clock and is driven by two single-cycle enables. `slow_en` marks each edge of the slow oscillator. `sec_tick` marks each elapsed second. The current time of day is held as hours, minutes and seconds. The current date is held as day of month, month, a year offset from a base year and a leap-year flag. Each group is read as one packed 32-bit word over a simple memory-mapped bus. A third word reports status.

A software write to the time word or the date word is not applied at once. The block stages the value and raises that word's busy bit in the status word. The staged value is loaded into the counter on the third `slow_en` pulse after the write, and the busy bit clears on the same edge. Software polls the busy bit before it writes the next word. While a word is waiting for its commit, second ticks do not advance it. The calendar rolls over from seconds up to years. The number of days in February comes from the stored leap flag, not from the year. Readers that need a coherent pair of words re-read until two reads agree, so the block keeps no snapshot.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, a read at offset 0x00 (status) returns 0, at 0x04 (date) returns 0x00000101 (day 1, month 1, year 0, leap 0), and at 0x08 (time) returns 0. Offsets other than these read 0.
- R2: The time word packs seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. All other bits read 0, and a committed write reads back with exactly that packing.
- R3: The date word packs day in bits 4:0, month (1..12) in bits 11:8, the year offset in YEAR_W bits starting at bit 16, and the leap flag at bit 16+YEAR_W (bit 24 when YEAR_W is 8). All other bits read 0.
- R4: A time write sets status bit 8 from the next cycle on. The time word keeps its old value until the third `slow_en` pulse after the write. On that edge the new value is loaded and bit 8 clears. A `slow_en` pulse in the same cycle as the write is not counted.
- R5: A date write sets status bit 7 and commits after three `slow_en` pulses, with the same timing as R4.
- R6: While a word's busy bit is set, `sec_tick` does not advance that word. A day carry produced while the date is busy is dropped, and the committed date is exactly the value written.
- R7: On `sec_tick`, seconds count 0..59 and wrap to 0 with a carry into minutes. Minutes wrap 59→0 with a carry into hours. Hours wrap 23→0 with a carry into the day.
- R8: On a day carry, the day wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. February wraps after 28 when the leap flag is 0 and after 29 when it is 1. The leap flag itself is not changed.
- R9: When the day wraps in month 12, the month becomes 1 and the year offset increments. At its field maximum (255 for YEAR_W=8) the year offset stays put.
- R10: Writes to the status offset change nothing. A second write to a word that is still busy restarts that word's three-pulse window, and only the newest value is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_en | input | 1 | One-cycle enable per slow oscillator edge |
| sec_tick | input | 1 | One-cycle enable per elapsed second |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational; 0 when bus_sel is low |

## Verification
The rollover tests start the counter one second before each boundary. These are the second, minute and hour wraps, the ends of 30-day, 31-day, leap and non-leap February months, the year end, and the year end at the maximum offset. Each test separates a correct wrap from an off-by-one in month length or saturation. The commit tests count `slow_en` pulses around a write. One pulse lands on the write cycle itself, which shows whether the window is counted from the right edge. Second ticks issued while a word is busy show whether the word was frozen and whether a carry leaked into a busy date. A rewrite during a pending commit shows that the window restarts with the newest value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Register byte offsets (bus map)
    localparam int unsigned OFF_STATUS = 0;
    localparam int unsigned OFF_DATE   = 4;
    localparam int unsigned OFF_TIME   = 8;

    // Status word bit positions
    localparam int unsigned BIT_TIME_BUSY = 8;
    localparam int unsigned BIT_DATE_BUSY = 7;

    // Slow-clock enables needed to commit a staged write
    localparam int unsigned COMMIT_PULSES = 3;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } hms_t;

    typedef struct packed {
        logic       leap;
        logic [7:0] year;
        logic [3:0] month;
        logic [4:0] day;
    } ymd_t;

    function automatic logic [31:0] hms_pack(input hms_t t);
        logic [31:0] w;
        w        = '0;
        w[5:0]   = t.sec;
        w[13:8]  = t.min;
        w[20:16] = t.hour;
        return w;
    endfunction

    function automatic hms_t hms_unpack(input logic [31:0] w);
        hms_t t;
        t.sec  = w[5:0];
        t.min  = w[13:8];
        t.hour = w[20:16];
        return t;
    endfunction

    // Year field is yw bits wide; the leap flag sits right above it.
    function automatic logic [31:0] ymd_pack(input ymd_t d, input int unsigned yw);
        logic [31:0] w;
        w       = '0;
        w[4:0]  = d.day;
        w[11:8] = d.month;
        for (int i = 0; i < 8; i++) begin
            if (i < yw) w[16+i] = d.year[i];
        end
        w[16+yw] = d.leap;
        return w;
    endfunction

    function automatic ymd_t ymd_unpack(input logic [31:0] w, input int unsigned yw);
        ymd_t d;
        d.day   = w[4:0];
        d.month = w[11:8];
        d.year  = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < yw) d.year[i] = w[16+i];
        end
        d.leap  = w[16+yw];
        return d;
    endfunction

    // Last day of a month; February depends on the stored leap flag.
    function automatic logic [4:0] month_last_day(input logic [3:0] month, input logic leap);
        case (month)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_commit_ctl.sv
// Stages one register write and releases it after a fixed number of
// slow-clock enables. A new write restarts the window.
module rtc_commit_ctl #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PULSES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              slow_en,
    output logic              busy,
    output logic              commit,
    output logic [DATA_W-1:0] staged
);
    localparam int unsigned CNT_W = $clog2(PULSES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Final counted pulse; a write in the same cycle takes precedence.
    assign commit = busy && slow_en && (cnt_q == LAST) && !wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            staged <= '0;
        end else if (wr) begin
            busy   <= 1'b1;
            cnt_q  <= '0;
            staged <= wdata;
        end else if (busy && slow_en) begin
            if (cnt_q == LAST) begin
                busy  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_time_ctr.sv
// Hours/minutes/seconds counter advanced by the one-second tick.
module rtc_time_ctr
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    input  logic load,
    input  hms_t load_val,
    output hms_t cur,
    output logic day_carry
);
    logic step;
    logic sec_last, min_last, hour_last;

    always_comb begin
        step      = tick && !hold;
        sec_last  = cur.sec  >= 6'd59;
        min_last  = cur.min  >= 6'd59;
        hour_last = cur.hour >= 5'd23;
        day_carry = step && sec_last && min_last && hour_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (step) begin
            if (!sec_last) begin
                cur.sec <= cur.sec + 1'b1;
            end else begin
                cur.sec <= '0;
                if (!min_last) begin
                    cur.min <= cur.min + 1'b1;
                end else begin
                    cur.min  <= '0;
                    cur.hour <= hour_last ? 5'd0 : cur.hour + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_date_ctr.sv
// Day/month/year counter advanced by the day carry of the time counter.
module rtc_date_ctr
    import rtc_cal_pkg::*;
#(
    parameter int unsigned YEAR_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic hold,
    input  logic load,
    input  ymd_t load_val,
    output ymd_t cur
);
    localparam logic [7:0] YEAR_MAX = 8'((1 << YEAR_W) - 1);

    logic       step;
    logic [4:0] last_day;

    always_comb begin
        step     = adv && !hold;
        last_day = month_last_day(cur.month, cur.leap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.leap  <= 1'b0;
            cur.year  <= '0;
            cur.month <= 4'd1;
            cur.day   <= 5'd1;
        end else if (load) begin
            cur <= load_val;
        end else if (step) begin
            if (cur.day < last_day) begin
                cur.day <= cur.day + 1'b1;
            end else begin
                cur.day <= 5'd1;
                if (cur.month < 4'd12) begin
                    cur.month <= cur.month + 1'b1;
                end else begin
                    cur.month <= 4'd1;
                    if (cur.year < YEAR_MAX) cur.year <= cur.year + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
// Calendar RTC: bus decode, two deferred-commit channels, counters.
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned YEAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_en,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    // Channel 0 = time word, channel 1 = date word
    localparam int unsigned NCH = 2;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_DATE   = ADDR_W'(OFF_DATE);
    localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(OFF_TIME);

    logic [NCH-1:0] ch_wr, ch_busy, ch_commit;
    logic [31:0]    ch_wdata  [NCH];
    logic [31:0]    ch_staged [NCH];

    logic time_busy, date_busy;
    hms_t time_q;
    ymd_t date_q;
    logic day_carry;

    always_comb begin
        ch_wr[0]    = bus_sel && bus_wr && (bus_addr == A_TIME);
        ch_wr[1]    = bus_sel && bus_wr && (bus_addr == A_DATE);
        // Stage only the implemented fields
        ch_wdata[0] = hms_pack(hms_unpack(bus_wdata));
        ch_wdata[1] = ymd_pack(ymd_unpack(bus_wdata, YEAR_W), YEAR_W);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        rtc_commit_ctl #(
            .DATA_W (32),
            .PULSES (COMMIT_PULSES)
        ) u_commit (
            .clk     (clk),
            .rst     (rst),
            .wr      (ch_wr[g]),
            .wdata   (ch_wdata[g]),
            .slow_en (slow_en),
            .busy    (ch_busy[g]),
            .commit  (ch_commit[g]),
            .staged  (ch_staged[g])
        );
    end

    assign time_busy = ch_busy[0];
    assign date_busy = ch_busy[1];

    rtc_time_ctr u_time (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .hold      (time_busy),
        .load      (ch_commit[0]),
        .load_val  (hms_unpack(ch_staged[0])),
        .cur       (time_q),
        .day_carry (day_carry)
    );

    rtc_date_ctr #(
        .YEAR_W (YEAR_W)
    ) u_date (
        .clk      (clk),
        .rst      (rst),
        .adv      (day_carry),
        .hold     (date_busy),
        .load     (ch_commit[1]),
        .load_val (ymd_unpack(ch_staged[1], YEAR_W)),
        .cur      (date_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == A_STATUS) begin
                bus_rdata[BIT_TIME_BUSY] = time_busy;
                bus_rdata[BIT_DATE_BUSY] = date_busy;
            end else if (bus_addr == A_DATE) begin
                bus_rdata = ymd_pack(date_q, YEAR_W);
            end else if (bus_addr == A_TIME) begin
                bus_rdata = hms_pack(time_q);
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned YEAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              slow_en,
    input logic              sec_tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input hms_t              t_cur,
    input ymd_t              d_cur,
    input logic              time_busy,
    input logic              date_busy
);
    localparam logic [7:0] YMAX = 8'((1 << YEAR_W) - 1);

    p_time_busy_set_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_TIME)) |=> time_busy);

    p_date_busy_set_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DATE)) |=> date_busy);

    p_busy_drop_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(time_busy) |-> $past(slow_en));

    p_time_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (time_busy && !slow_en) |=> $stable(t_cur));

    p_date_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (date_busy && !slow_en) |=> $stable(d_cur));

    p_sec_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !time_busy && t_cur.sec == 6'd59) |=> (t_cur.sec == 6'd0));

    p_year_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (d_cur.year == YMAX && !date_busy) |=> (d_cur.year == YMAX));
endmodule

bind rtc_calendar rtc_calendar_chk #(
    .ADDR_W (ADDR_W),
    .YEAR_W (YEAR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slow_en   (slow_en),
    .sec_tick  (sec_tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .t_cur     (time_q),
    .d_cur     (date_q),
    .time_busy (time_busy),
    .date_busy (date_busy)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
    localparam int ADDR_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slow_en = 1'b0, sec_tick = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    rtc_calendar #(.ADDR_W(ADDR_W), .YEAR_W(8)) uut (
        .clk(clk), .rst(rst), .slow_en(slow_en), .sec_tick(sec_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mk_time(int h, int m, int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] mk_date(int d, int mo, int y, int lp);
        return (32'(lp) << 24) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Called at a negedge; samples combinational read data mid-cycle.
    task automatic rd(input int addr, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(string req, int addr, logic [31:0] exp);
        logic [31:0] v;
        rd(addr, v);
        check(req, v, exp);
    endtask

    task automatic wr(int addr, logic [31:0] d, bit with_slow = 0);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = d;
        slow_en = with_slow;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; slow_en = 1'b0;
    endtask

    task automatic slow_pulse(int n);
        for (int i = 0; i < n; i++) begin
            slow_en = 1'b1; @(posedge clk); @(negedge clk); slow_en = 1'b0;
        end
    endtask

    task automatic sec_pulse(int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; @(posedge clk); @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic set_time(logic [31:0] v); wr(8, v); slow_pulse(3); endtask
    task automatic set_date(logic [31:0] v); wr(4, v); slow_pulse(3); endtask

    task automatic t_reset;
        rd_chk("R1 status", 0, 32'h0);
        rd_chk("R1 date", 4, 32'h0000_0101);
        rd_chk("R1 time", 8, 32'h0);
        rd_chk("R1 unmapped", 12, 32'h0);
    endtask

    task automatic t_time_commit;
        logic [31:0] v = mk_time(12, 34, 56);
        wr(8, v | 32'hFFE0_C0C0, 1);            // slow_en on write cycle not counted
        rd_chk("R4 busy bit8", 0, 32'h100);
        rd_chk("R4 old time kept", 8, 32'h0);
        slow_pulse(2);
        rd_chk("R4 busy after 2", 0, 32'h100);
        rd_chk("R4 old after 2", 8, 32'h0);
        slow_pulse(1);
        rd_chk("R4 busy clear", 0, 32'h0);
        rd_chk("R2 time packing", 8, v);
    endtask

    task automatic t_date_commit;
        logic [31:0] v = mk_date(15, 6, 20, 1);
        wr(4, v | 32'hFE00_F0E0);
        rd_chk("R5 busy bit7", 0, 32'h80);
        rd_chk("R5 old date", 4, 32'h0000_0101);
        slow_pulse(2);
        rd_chk("R5 busy after 2", 0, 32'h80);
        slow_pulse(1);
        rd_chk("R5 busy clear", 0, 32'h0);
        rd_chk("R3 date packing", 4, v);
    endtask

    task automatic t_hold;
        set_time(mk_time(10, 0, 0));
        wr(8, mk_time(11, 11, 11));
        sec_pulse(3);
        rd_chk("R6 time frozen", 8, mk_time(10, 0, 0));
        slow_pulse(3);
        rd_chk("R6 time exact", 8, mk_time(11, 11, 11));
        set_time(mk_time(23, 59, 59));
        set_date(mk_date(10, 3, 5, 0));
        wr(4, mk_date(20, 7, 9, 0));
        sec_pulse(1);
        rd_chk("R6 time runs", 8, mk_time(0, 0, 0));
        rd_chk("R6 date frozen", 4, mk_date(10, 3, 5, 0));
        slow_pulse(3);
        rd_chk("R6 carry dropped", 4, mk_date(20, 7, 9, 0));
    endtask

    task automatic t_time_roll;
        set_date(mk_date(10, 3, 5, 0));
        set_time(mk_time(23, 59, 58));
        sec_pulse(1);
        rd_chk("R7 sec step", 8, mk_time(23, 59, 59));
        sec_pulse(1);
        rd_chk("R7 hour wrap", 8, mk_time(0, 0, 0));
        rd_chk("R7 day carry", 4, mk_date(11, 3, 5, 0));
        set_time(mk_time(0, 0, 59));
        sec_pulse(1);
        rd_chk("R7 min carry", 8, mk_time(0, 1, 0));
        set_time(mk_time(0, 59, 59));
        sec_pulse(1);
        rd_chk("R7 hour carry", 8, mk_time(1, 0, 0));
    endtask

    task automatic roll_day(string req, logic [31:0] d0, logic [31:0] d1);
        set_date(d0);
        set_time(mk_time(23, 59, 59));
        sec_pulse(1);
        rd_chk(req, 4, d1);
    endtask

    task automatic t_month_len;
        roll_day("R8 30-day month", mk_date(30, 4, 3, 0), mk_date(1, 5, 3, 0));
        roll_day("R8 31-day no wrap", mk_date(30, 1, 3, 0), mk_date(31, 1, 3, 0));
        roll_day("R8 31-day wrap", mk_date(31, 1, 3, 0), mk_date(1, 2, 3, 0));
        roll_day("R8 feb non-leap", mk_date(28, 2, 3, 0), mk_date(1, 3, 3, 0));
        roll_day("R8 feb leap 29", mk_date(28, 2, 2, 1), mk_date(29, 2, 2, 1));
        set_time(mk_time(23, 59, 59));
        sec_pulse(1);
        rd_chk("R8 feb leap wrap", 4, mk_date(1, 3, 2, 1));
    endtask

    task automatic t_year;
        roll_day("R9 year step", mk_date(31, 12, 7, 0), mk_date(1, 1, 8, 0));
        roll_day("R9 year saturate", mk_date(31, 12, 255, 0), mk_date(1, 1, 255, 0));
    endtask

    task automatic t_ignore_restart;
        set_time(mk_time(5, 6, 7));
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R10 status write ignored", 0, 32'h0);
        rd_chk("R10 time untouched", 8, mk_time(5, 6, 7));
        wr(8, mk_time(1, 2, 3));
        slow_pulse(2);
        wr(8, mk_time(4, 5, 6));
        slow_pulse(2);
        rd_chk("R10 restart busy", 0, 32'h100);
        rd_chk("R10 restart old", 8, mk_time(5, 6, 7));
        slow_pulse(1);
        rd_chk("R10 newest value", 8, mk_time(4, 5, 6));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_time_commit();
        t_date_commit();
        t_hold();
        t_time_roll();
        t_month_len();
        t_year();
        t_ignore_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule